// File: doc/BRIEF.md
# Split-Mode Capture Timer

This block is a 16-bit counter that can be used whole or split into two 8-bit halves. A 2-bit mode field selects the arrangement. In mode 0 both halves are timers. In mode 1 the low half is a timer and the high half counts events. Mode 2 is one wide timer and mode 3 is one wide event counter. Timer counts advance on ticks from an 8-bit reloading prescaler. Event counts advance on rising edges of an external pin, which first passes through a synchroniser. Each half has a match value. When a count reaches its match value, the count wraps to zero and a sticky interrupt flag is set. Two capture strobes copy the full 16-bit count into capture register A or capture register B. In the split modes, each of those registers holds one byte for each half.

A small control state machine runs the counting. ST_IDLE holds everything still. It moves to ST_RUN when the run bit is written as 1. ST_RUN counts. It goes back to ST_IDLE when the run bit is written as 0. A control write that carries a different mode sends either state to ST_CLEAR. ST_CLEAR lasts one cycle, or longer while writes with a different mode keep arriving. During it the counters and the prescaler are reset. It then moves to ST_RUN or ST_IDLE according to the run bit. Software uses a write port and a combinational read port.

Top module: `capture_split_timer`

## Requirements
- R1: After reset the counts, flags, capture registers, match values and prescaler value are all zero. The control register reads 0, which means mode 0 and stopped.
- R2: Control is at write address 0: bits 1:0 are the mode and bit 2 is run. In mode 0, both 8-bit halves advance on each prescaler tick. Each half compares against its own match byte. The low match byte is at write address 2 and the high match byte is at write address 3.
- R3: The prescaler value N is at write address 1. The prescaler gives one tick every N+1 running cycles. After a clear it starts again from N, so K running cycles give floor(K/(N+1)) ticks.
- R4: In mode 1, the low half counts prescaler ticks and the high half counts rising edges of ev_pin. A pin level that is held counts only once. An edge is counted two clocks after it is first sampled.
- R5: In mode 2, the 16-bit count advances on prescaler ticks, and a carry out of the low byte increments the high byte.
- R6: In mode 3, the 16-bit count advances once for each rising edge of ev_pin.
- R7: On a tick where a count equals its match value, the count goes to 0 and its flag is set. In the wide modes, the 16-bit match sets irq_lo only, and irq_hi is never set.
- R8: Writing to write address 4 clears flags: a 1 in bit 0 clears irq_lo and a 1 in bit 1 clears irq_hi. A 0 bit leaves its flag alone. A flag stays set until it is cleared this way. Flags read back at read address 4 as {irq_hi, irq_lo}.
- R9: cap_a and cap_b copy {high, low} into capture register A or capture register B. The value copied is the count before any increment in that same cycle. Register A reads at addresses 7 (low) and 8 (high). Register B reads at addresses 9 (low) and 10 (high). The count reads at addresses 5 (low) and 6 (high).
- R10: A control write with a new mode clears both counts and reloads the prescaler in the following cycle. Match values and capture registers are kept. A control write with the same mode only changes run.
- R11: While run is 0, the counts and the prescaler do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ev_pin | input | 1 | External event pin, asynchronous |
| cap_a | input | 1 | Capture strobe for register A |
| cap_b | input | 1 | Capture strobe for register B |
| irq_lo | output | 1 | Sticky flag for the low half or the wide unit |
| irq_hi | output | 1 | Sticky flag for the high half |

## Verification
The vector table goes after the prescaler divide of N+1, wrap at the match value, the 8-bit rollover at 255, and the carry from the low byte into the high byte in mode 2. A divide off by one, or a wrap one count late, shifts every expected count. An event pulse held high for ten cycles checks that a level is counted once: a design that counts levels would report far more events. The capture checks strobe during counting and expect the value before the increment; a design that captures after the increment reads one higher. The mode-change check looks at the cycle just after ST_CLEAR. It also confirms that a write with the same mode does not clear the counts and that the capture registers survive the clear.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL_TMR = 2'd0,
        MODE_TMR_EVT  = 2'd1,
        MODE_WIDE_TMR = 2'd2,
        MODE_WIDE_EVT = 2'd3
    } cst_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } cst_state_e;

    localparam logic [2:0] WA_CTRL    = 3'd0;
    localparam logic [2:0] WA_PRESC   = 3'd1;
    localparam logic [2:0] WA_MATCH_L = 3'd2;
    localparam logic [2:0] WA_MATCH_H = 3'd3;
    localparam logic [2:0] WA_FLAGCLR = 3'd4;
endpackage

// File: rtl/cst_prescaler.sv
module cst_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [PRESC_W-1:0] reload,
    output logic               tick
);
    logic [PRESC_W-1:0] pc_q;

    // one tick per wrap; the down counter reloads from the programmed value
    assign tick = en && (pc_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (clr) begin
            pc_q <= reload;
        end else if (en) begin
            if (pc_q == '0) begin
                pc_q <= reload;
            end else begin
                pc_q <= pc_q - PRESC_W'(1);
            end
        end
    end
endmodule

// File: rtl/cst_edge_sync.sv
module cst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin};
        end
    end

    // last synchronised stage against its one-cycle-older copy
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cst_count_core.sv
module cst_count_core #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wide,
    input  logic              lo_inc,
    input  logic              hi_inc,
    input  logic              wide_inc,
    input  logic [HALF_W-1:0] match_lo,
    input  logic [HALF_W-1:0] match_hi,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic              hit_lo,
    output logic              hit_hi
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] cnt_q;
    logic [FULL_W-1:0] cnt_d;
    logic [FULL_W-1:0] match_full;

    assign match_full = {match_hi, match_lo};

    always_comb begin
        cnt_d  = cnt_q;
        hit_lo = 1'b0;
        hit_hi = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (wide) begin
            if (wide_inc) begin
                if (cnt_q == match_full) begin
                    cnt_d  = '0;
                    hit_lo = 1'b1;
                end else begin
                    cnt_d = cnt_q + FULL_W'(1);
                end
            end
        end else begin
            if (lo_inc) begin
                if (cnt_q[HALF_W-1:0] == match_lo) begin
                    cnt_d[HALF_W-1:0] = '0;
                    hit_lo = 1'b1;
                end else begin
                    cnt_d[HALF_W-1:0] = cnt_q[HALF_W-1:0] + HALF_W'(1);
                end
            end
            if (hi_inc) begin
                if (cnt_q[FULL_W-1:HALF_W] == match_hi) begin
                    cnt_d[FULL_W-1:HALF_W] = '0;
                    hit_hi = 1'b1;
                end else begin
                    cnt_d[FULL_W-1:HALF_W] = cnt_q[FULL_W-1:HALF_W] + HALF_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_lo = cnt_q[HALF_W-1:0];
    assign cnt_hi = cnt_q[FULL_W-1:HALF_W];
endmodule

// File: rtl/capture_split_timer.sv
module capture_split_timer
    import cst_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRESC_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [3:0]        rd_addr,
    output logic [HALF_W-1:0] rd_data,
    input  logic              ev_pin,
    input  logic              cap_a,
    input  logic              cap_b,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int FULL_W = 2 * HALF_W;

    cst_mode_e          mode_q;
    logic               run_q;
    logic [PRESC_W-1:0] presc_q;
    logic [HALF_W-1:0]  match_lo_q;
    logic [HALF_W-1:0]  match_hi_q;
    logic [FULL_W-1:0]  cap_a_q;
    logic [FULL_W-1:0]  cap_b_q;
    logic [FULL_W-1:0]  cnt_full;
    logic [HALF_W-1:0]  cnt_lo;
    logic [HALF_W-1:0]  cnt_hi;
    logic               irq_lo_q;
    logic               irq_hi_q;

    cst_state_e state_q;
    cst_state_e state_d;

    logic ctrl_wr;
    logic mode_chg;
    logic run_nxt;
    logic cnt_en;
    logic clr;
    logic pre_tick;
    logic ev_rise;
    logic lo_inc;
    logic hi_inc;
    logic wide_inc;
    logic hit_lo;
    logic hit_hi;
    logic clr_lo;
    logic clr_hi;

    assign ctrl_wr  = wr_en && (wr_addr == WA_CTRL);
    assign mode_chg = ctrl_wr && (wr_data[1:0] != mode_q);
    assign run_nxt  = ctrl_wr ? wr_data[2] : run_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_chg)     state_d = ST_CLEAR;
                else if (run_nxt) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (mode_chg)      state_d = ST_CLEAR;
                else if (!run_nxt) state_d = ST_IDLE;
            end
            ST_CLEAR: begin
                if (mode_chg) state_d = ST_CLEAR;
                else          state_d = run_nxt ? ST_RUN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        cnt_en = 1'b0;
        clr    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RUN:   cnt_en = 1'b1;
            ST_CLEAR: clr    = 1'b1;
            default:  ;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_DUAL_TMR;
            run_q      <= 1'b0;
            presc_q    <= '0;
            match_lo_q <= '0;
            match_hi_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                WA_CTRL: begin
                    mode_q <= cst_mode_e'(wr_data[1:0]);
                    run_q  <= wr_data[2];
                end
                WA_PRESC:   presc_q    <= wr_data[PRESC_W-1:0];
                WA_MATCH_L: match_lo_q <= wr_data;
                WA_MATCH_H: match_hi_q <= wr_data;
                default: ;
            endcase
        end
    end

    cst_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (cnt_en),
        .reload (presc_q),
        .tick   (pre_tick)
    );

    cst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ev_pin),
        .rise  (ev_rise)
    );

    assign lo_inc   = cnt_en && pre_tick;
    assign hi_inc   = cnt_en && ((mode_q == MODE_DUAL_TMR) ? pre_tick : ev_rise);
    assign wide_inc = cnt_en && ((mode_q == MODE_WIDE_TMR) ? pre_tick : ev_rise);

    cst_count_core #(.HALF_W(HALF_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wide     (mode_q[1]),
        .lo_inc   (lo_inc),
        .hi_inc   (hi_inc),
        .wide_inc (wide_inc),
        .match_lo (match_lo_q),
        .match_hi (match_hi_q),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi),
        .hit_lo   (hit_lo),
        .hit_hi   (hit_hi)
    );

    assign cnt_full = {cnt_hi, cnt_lo};

    // capture: registered count is the pre-increment value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a_q <= '0;
            cap_b_q <= '0;
        end else begin
            if (cap_a) cap_a_q <= cnt_full;
            if (cap_b) cap_b_q <= cnt_full;
        end
    end

    // sticky flags: a set in the same cycle wins over a clear
    assign clr_lo = wr_en && (wr_addr == WA_FLAGCLR) && wr_data[0];
    assign clr_hi = wr_en && (wr_addr == WA_FLAGCLR) && wr_data[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_lo_q <= 1'b0;
            irq_hi_q <= 1'b0;
        end else begin
            irq_lo_q <= (irq_lo_q && !clr_lo) || hit_lo;
            irq_hi_q <= (irq_hi_q && !clr_hi) || hit_hi;
        end
    end

    assign irq_lo = irq_lo_q;
    assign irq_hi = irq_hi_q;

    always_comb begin
        case (rd_addr)
            4'd0:    rd_data = HALF_W'({run_q, mode_q});
            4'd1:    rd_data = HALF_W'(presc_q);
            4'd2:    rd_data = match_lo_q;
            4'd3:    rd_data = match_hi_q;
            4'd4:    rd_data = HALF_W'({irq_hi_q, irq_lo_q});
            4'd5:    rd_data = cnt_lo;
            4'd6:    rd_data = cnt_hi;
            4'd7:    rd_data = cap_a_q[HALF_W-1:0];
            4'd8:    rd_data = cap_a_q[FULL_W-1:HALF_W];
            4'd9:    rd_data = cap_b_q[HALF_W-1:0];
            4'd10:   rd_data = cap_b_q[FULL_W-1:HALF_W];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cst_checker.sv
module cst_checker
    import cst_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [2:0]            wr_addr,
    input logic [HALF_W-1:0]     wr_data,
    input logic                  cap_a,
    input logic [1:0]            mode,
    input cst_state_e            state,
    input logic [2*HALF_W-1:0]   cnt,
    input logic [2*HALF_W-1:0]   cap_a_val,
    input logic                  irq_lo,
    input logic                  irq_hi
);
    // R9
    cap_pre_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> (cap_a_val == $past(cnt)));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (cnt == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(cnt));

    // R8
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && !(wr_en && (wr_addr == WA_FLAGCLR) && wr_data[0])) |=> irq_lo);

    // R7
    wide_no_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !irq_hi) |=> !irq_hi);
endmodule

bind capture_split_timer cst_checker #(.HALF_W(HALF_W)) u_cst_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cap_a     (cap_a),
    .mode      (mode_q),
    .state     (state_q),
    .cnt       (cnt_full),
    .cap_a_val (cap_a_q),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi)
);

// File: tb/capture_split_timer_bench.sv
module capture_split_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // [59:58] mode [57:50] presc [49:42] mlo [41:34] mhi [33:18] run cycles
    // [17:10] exp lo [9:2] exp hi [1:0] exp flags {hi,lo}
    localparam logic [59:0] VECS [NV] = '{
        {2'd0, 8'd0, 8'd255, 8'd255, 16'd10,  8'd10, 8'd10, 2'b00},
        {2'd0, 8'd3, 8'd4,   8'd255, 16'd28,  8'd2,  8'd7,  2'b01},
        {2'd0, 8'd1, 8'd255, 8'd2,   16'd14,  8'd7,  8'd1,  2'b10},
        {2'd2, 8'd0, 8'd255, 8'd255, 16'd260, 8'd4,  8'd1,  2'b00},
        {2'd2, 8'd0, 8'd5,   8'd1,   16'd300, 8'd38, 8'd0,  2'b01},
        {2'd2, 8'd2, 8'd255, 8'd255, 16'd30,  8'd10, 8'd0,  2'b00},
        {2'd0, 8'd0, 8'd255, 8'd255, 16'd258, 8'd2,  8'd2,  2'b11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ev_pin = 1'b0;
    logic       cap_a = 1'b0;
    logic       cap_b = 1'b0;
    logic       irq_lo;
    logic       irq_hi;

    int checks = 0;
    int errors = 0;
    logic [59:0] v;
    logic [7:0]  rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    capture_split_timer u_capture_split_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ev_pin  (ev_pin),
        .cap_a   (cap_a),
        .cap_b   (cap_b),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] m, input logic [7:0] p,
                       input logic [7:0] ml, input logic [7:0] mh);
        wr(3'd1, p);
        wr(3'd2, ml);
        wr(3'd3, mh);
        wr(3'd4, 8'h03);
        wr(3'd0, {6'd0, m ^ 2'd1});
        wr(3'd0, {6'd0, m});
    endtask

    task automatic pulse(input int hi_cyc, input int lo_cyc);
        ev_pin = 1'b1;
        repeat (hi_cyc) @(negedge clk);
        ev_pin = 1'b0;
        repeat (lo_cyc) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, rv); chk("R1 ctrl", rv, 8'h00);
        rd(4'd5, rv); chk("R1 cnt lo", rv, 8'h00);
        rd(4'd6, rv); chk("R1 cnt hi", rv, 8'h00);
        chk("R1 flags", {irq_hi, irq_lo}, 2'b00);

        // R2 R3 R5 R7 R11: vector walk
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            cfg(v[59:58], v[57:50], v[49:42], v[41:34]);
            wr(3'd0, {5'd0, 1'b1, v[59:58]});
            repeat (int'(v[33:18]) - 1) @(negedge clk);
            wr(3'd0, {5'd0, 1'b0, v[59:58]});
            repeat (3) @(negedge clk);
            rd(4'd5, rv); chk("R2/R3/R5 count lo, R11 frozen", rv, v[17:10]);
            rd(4'd6, rv); chk("R2/R3/R5 count hi", rv, v[9:2]);
            rd(4'd4, rv); chk("R7 flags", rv, {6'd0, v[1:0]});
        end

        // R8 flag clear, both set from last vector
        wr(3'd4, 8'h02);
        chk("R8 clear hi only", {irq_hi, irq_lo}, 2'b01);
        wr(3'd4, 8'h00);
        chk("R8 zero write ignored", {irq_hi, irq_lo}, 2'b01);
        wr(3'd4, 8'h01);
        chk("R8 clear lo", {irq_hi, irq_lo}, 2'b00);

        // R4 mode 1: low timer, high counts edges
        cfg(2'd1, 8'd0, 8'd255, 8'd255);
        wr(3'd0, 8'h05);
        pulse(2, 2); pulse(2, 2); pulse(2, 2);
        repeat (4) @(negedge clk);
        wr(3'd0, 8'h01);
        rd(4'd5, rv); chk("R4 timer half", rv, 8'd17);
        rd(4'd6, rv); chk("R4 event half", rv, 8'd3);
        cap_b = 1'b1;
        @(negedge clk);
        cap_b = 1'b0;
        rd(4'd9, rv);  chk("R9 capB lo split", rv, 8'd17);
        rd(4'd10, rv); chk("R9 capB hi split", rv, 8'd3);

        // R10 same-mode write keeps counts, new mode clears
        wr(3'd0, 8'h01);
        rd(4'd5, rv); chk("R10 same mode keeps lo", rv, 8'd17);
        rd(4'd6, rv); chk("R10 same mode keeps hi", rv, 8'd3);
        wr(3'd0, 8'h00);
        @(negedge clk);
        rd(4'd5, rv); chk("R10 cleared lo", rv, 8'd0);
        rd(4'd6, rv); chk("R10 cleared hi", rv, 8'd0);
        rd(4'd10, rv); chk("R10 capture kept", rv, 8'd3);

        // R6 mode 3 events with match 2, long pulse counted once
        cfg(2'd3, 8'd0, 8'd2, 8'd0);
        wr(3'd0, 8'h07);
        pulse(1, 3); pulse(10, 3); pulse(2, 3); pulse(1, 4);
        wr(3'd0, 8'h03);
        rd(4'd5, rv); chk("R6 wide event lo", rv, 8'd1);
        rd(4'd6, rv); chk("R6 wide event hi", rv, 8'd0);
        chk("R7 wide match flags", {irq_hi, irq_lo}, 2'b01);

        // R9 capture in same cycle as increment, mode 2
        cfg(2'd2, 8'd0, 8'd255, 8'd255);
        wr(3'd0, 8'h06);
        repeat (4) @(negedge clk);
        cap_a = 1'b1;
        @(negedge clk);
        cap_a = 1'b0;
        repeat (9) @(negedge clk);
        cap_b = 1'b1;
        @(negedge clk);
        cap_b = 1'b0;
        wr(3'd0, 8'h02);
        rd(4'd7, rv); chk("R9 capA lo", rv, 8'd4);
        rd(4'd8, rv); chk("R9 capA hi", rv, 8'd0);
        rd(4'd9, rv); chk("R9 capB lo", rv, 8'd14);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule